// File: doc/BRIEF.md
# Planar Video Memory Write Datapath

This block turns one CPU byte write into a single write to a four-plane video memory. It takes the byte, its address, the graphics control register values, the four plane latches loaded by an earlier read, the chain-4 flag and the plane write mask. From these it produces the memory word address, up to eight data bytes and their byte enables. It implements the four standard write modes: rotate with set/reset, latch copy, colour expansion, and masked set/reset. It also implements two extended modes, enabled by a control bit, that expand a monochrome byte into eight colour bytes at a doubled address.

The result is registered, so a write offered on `wr_i` shows on the outputs one cycle later with `wr_valid_o`. A write whose plane-space address reaches the memory limit is dropped. A write in an undefined mode is also dropped. Latch loading, the read path and bank address translation sit outside this block.

Top module: `vga_plane_writer`

## Requirements
- R1: During and after reset, with no write offered, `wr_valid_o` is 0 and `wr_be_o` is 0.
- R2: The effective write mode is `mode_reg_i[2:0]` when `ext_ctrl_i[2]` is 1, and `{0, mode_reg_i[1:0]}` otherwise.
- R3: For modes 0 to 3, the base address is `addr_i` with bits 1:0 cleared when `chain4_i` is 1; otherwise it is `addr_i` shifted left by 2. The plane select is `1 << addr_i[1:0]` under chain-4 and all four planes otherwise. `wr_be_o[3:0]` is the plane select ANDed with `plane_mask_i`, `wr_be_o[7:4]` is 0, and `wr_addr_o` equals the base address. Plane p occupies data byte p.
- R4: Modes 0, 2 and 3 combine a value v with the latch l under a mask m, using `rot_func_i[4:3]`:
  - 0 gives `(v&m)|(l&~m)`.
  - 1 gives `(v|~m)&l`.
  - 2 gives `(v&m)|l`.
  - 3 gives `(v&m)^l`.
  Here m is `bit_mask_i`, except in mode 3.
- R5: In mode 0, the CPU byte is rotated right by `rot_func_i[2:0]`. For each plane p with `sr_enable_i[p]` set, v becomes 0xFF or 0x00 according to `set_reset_i[p]`.
- R6: Mode 1 writes latch byte p to plane p unchanged. In mode 2, v for plane p is 0xFF when `cpu_data_i[p]` is 1 and 0x00 otherwise.
- R7: In mode 3, v for plane p is 0xFF or 0x00 from `set_reset_i[p]`, and m is the rotated CPU byte ANDed with `bit_mask_i`.
- R8: In mode 4, `wr_addr_o` is the non-chained base address `addr_i<<2` shifted left by one more bit. Every data byte carries `sr_enable_i`, and byte enable i equals `cpu_data_i[7-i]`.
- R9: In mode 5, the address is as in R8 and all eight byte enables are 1. Byte i is `sr_enable_i` when `cpu_data_i[7-i]` is 1 and `set_reset_i` otherwise.
- R10: A write whose base address is greater than or equal to `limit_i` is dropped, as is any write in mode 6 or 7. A dropped write gives `wr_valid_o` 0 and `wr_be_o` 0.
- R11: An accepted write offered on `wr_i` at a clock edge appears on the outputs after that edge and lasts exactly one cycle. Outputs return to invalid when no write is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | CPU byte write strobe |
| cpu_data_i | input | 8 | CPU write byte |
| addr_i | input | ADDR_W | Byte address after banking |
| set_reset_i | input | 8 | Set/reset value; background colour in mode 5 |
| sr_enable_i | input | 8 | Set/reset enables; foreground colour in modes 4 and 5 |
| rot_func_i | input | 8 | Rotate count [2:0] and logic function [4:3] |
| mode_reg_i | input | 8 | Write mode field [2:0] |
| bit_mask_i | input | 8 | Bit mask |
| ext_ctrl_i | input | 8 | Bit 2 enables the 3-bit write mode |
| latch_i | input | 32 | Plane latches, plane p in byte p |
| chain4_i | input | 1 | Chain-4 addressing |
| plane_mask_i | input | 4 | Plane write mask |
| limit_i | input | ADDR_W+3 | Memory limit in base-address units |
| wr_valid_o | output | 1 | Registered write valid |
| wr_addr_o | output | ADDR_W+3 | Memory address |
| wr_data_o | output | 64 | Data bytes 0..7 |
| wr_be_o | output | 8 | Byte enables |

## Verification
A wrong mode decode or a wrong logic-function select shows up on the output in the very next cycle. The data bytes or enables then differ from those of the intended mode. Because every vector is checked one cycle after it is offered, a fault is pinned to the exact register setting that exposed it. The only internal state is the output register. A stuck enable or a stale valid therefore shows as nonzero enables or a valid in a cycle with no write, or after a dropped one. The bench checks those idle cycles explicitly.

// File: rtl/vga_wr_pkg.sv
package vga_wr_pkg;
  typedef enum logic [1:0] {
    FN_REPLACE = 2'd0,
    FN_AND     = 2'd1,
    FN_OR      = 2'd2,
    FN_XOR     = 2'd3
  } logic_fn_e;

  function automatic logic [7:0] rotr8(input logic [7:0] v, input logic [2:0] n);
    logic [15:0] dbl;
    dbl = {v, v} >> n;
    return dbl[7:0];
  endfunction

  function automatic logic [7:0] combine(input logic_fn_e fn, input logic [7:0] v,
                                         input logic [7:0] m, input logic [7:0] l);
    case (fn)
      FN_REPLACE: return (v & m) | (l & ~m);
      FN_AND:     return (v | ~m) & l;
      FN_OR:      return (v & m) | l;
      default:    return (v & m) ^ l;
    endcase
  endfunction
endpackage

// File: rtl/vga_wr_addr.sv
module vga_wr_addr #(
  parameter int ADDR_W = 16,
  localparam int BA_W = ADDR_W + 2,
  localparam int OA_W = ADDR_W + 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              chain4_i,
  input  logic [2:0]        mode_i,
  input  logic [3:0]        plane_mask_i,
  input  logic [OA_W-1:0]   limit_i,
  output logic [OA_W-1:0]   out_addr_o,
  output logic [3:0]        plane_be_o,
  output logic              drop_o
);
  logic          chained;
  logic [BA_W-1:0] base;

  assign chained = chain4_i && !mode_i[2];
  assign base    = chained ? {2'b00, addr_i[ADDR_W-1:2], 2'b00} : {addr_i, 2'b00};

  always_comb begin
    if (chained) plane_be_o = (4'b0001 << addr_i[1:0]) & plane_mask_i;
    else         plane_be_o = plane_mask_i;
    // extended modes double the address
    if (mode_i[2]) out_addr_o = {base, 1'b0};
    else           out_addr_o = {1'b0, base};
  end

  assign drop_o = ({1'b0, base} >= limit_i);

  always_comb begin
    if (chained) a_r3_chain_onehot: assert ($countones(plane_be_o) <= 1);
  end
endmodule

// File: rtl/vga_wr_logic.sv
module vga_wr_logic
  import vga_wr_pkg::*;
#(
  parameter int PLANES = 4,
  localparam int DW = PLANES * 8
) (
  input  logic [1:0]    mode_i,
  input  logic [7:0]    cpu_data_i,
  input  logic [7:0]    set_reset_i,
  input  logic [7:0]    sr_enable_i,
  input  logic [7:0]    rot_func_i,
  input  logic [7:0]    bit_mask_i,
  input  logic [DW-1:0] latch_i,
  output logic [DW-1:0] data_o
);
  logic [7:0] rot;
  logic_fn_e  fn;

  assign rot = rotr8(cpu_data_i, rot_func_i[2:0]);
  assign fn  = logic_fn_e'(rot_func_i[4:3]);

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [7:0] lat, val, msk;
    assign lat = latch_i[p*8 +: 8];
    always_comb begin
      msk = bit_mask_i;
      case (mode_i)
        2'd0: val = sr_enable_i[p] ? {8{set_reset_i[p]}} : rot;
        2'd2: val = {8{cpu_data_i[p]}};
        2'd3: begin
          val = {8{set_reset_i[p]}};
          msk = bit_mask_i & rot;
        end
        default: val = lat;
      endcase
    end
    assign data_o[p*8 +: 8] = (mode_i == 2'd1) ? lat : combine(fn, val, msk, lat);
  end
endmodule

// File: rtl/vga_wr_expand.sv
module vga_wr_expand #(
  parameter int LANES = 8,
  localparam int DW = LANES * 8
) (
  input  logic          fill_bg_i,
  input  logic [7:0]    cpu_data_i,
  input  logic [7:0]    fg_i,
  input  logic [7:0]    bg_i,
  output logic [DW-1:0] data_o,
  output logic [LANES-1:0] be_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic bit_set;
    assign bit_set = cpu_data_i[LANES-1-i];
    assign data_o[i*8 +: 8] = (fill_bg_i && !bit_set) ? bg_i : fg_i;
    assign be_o[i] = fill_bg_i | bit_set;
  end
endmodule

// File: rtl/vga_plane_writer.sv
module vga_plane_writer #(
  parameter int ADDR_W = 16,
  localparam int OA_W = ADDR_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        set_reset_i,
  input  logic [7:0]        sr_enable_i,
  input  logic [7:0]        rot_func_i,
  input  logic [7:0]        mode_reg_i,
  input  logic [7:0]        bit_mask_i,
  input  logic [7:0]        ext_ctrl_i,
  input  logic [31:0]       latch_i,
  input  logic              chain4_i,
  input  logic [3:0]        plane_mask_i,
  input  logic [OA_W-1:0]   limit_i,
  output logic              wr_valid_o,
  output logic [OA_W-1:0]   wr_addr_o,
  output logic [63:0]       wr_data_o,
  output logic [7:0]        wr_be_o
);
  logic [2:0]      mode;
  logic [OA_W-1:0] addr_n;
  logic [3:0]      plane_be;
  logic            drop, accept;
  logic [31:0]     plane_data;
  logic [63:0]     exp_data, data_n;
  logic [7:0]      exp_be, be_n;

  assign mode = ext_ctrl_i[2] ? mode_reg_i[2:0] : {1'b0, mode_reg_i[1:0]};

  vga_wr_addr #(.ADDR_W(ADDR_W)) u_addr (
    .addr_i(addr_i), .chain4_i(chain4_i), .mode_i(mode),
    .plane_mask_i(plane_mask_i), .limit_i(limit_i),
    .out_addr_o(addr_n), .plane_be_o(plane_be), .drop_o(drop)
  );

  vga_wr_logic #(.PLANES(4)) u_logic (
    .mode_i(mode[1:0]), .cpu_data_i(cpu_data_i), .set_reset_i(set_reset_i),
    .sr_enable_i(sr_enable_i), .rot_func_i(rot_func_i), .bit_mask_i(bit_mask_i),
    .latch_i(latch_i), .data_o(plane_data)
  );

  vga_wr_expand #(.LANES(8)) u_expand (
    .fill_bg_i(mode[0]), .cpu_data_i(cpu_data_i), .fg_i(sr_enable_i),
    .bg_i(set_reset_i), .data_o(exp_data), .be_o(exp_be)
  );

  assign accept = wr_i && !drop && (mode < 3'd6);
  assign data_n = mode[2] ? exp_data : {32'h0, plane_data};
  assign be_n   = mode[2] ? exp_be : {4'h0, plane_be};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_be_o    <= '0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= accept;
      wr_be_o    <= accept ? be_n : 8'h00;
      if (accept) begin
        wr_addr_o <= addr_n;
        wr_data_o <= data_n;
      end
    end
  end

  a_r1_idle_no_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_o |-> wr_be_o == 8'h00);
  a_r3_upper_lanes_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !mode[2]) |=> wr_be_o[7:4] == 4'h0);
  a_r9_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode == 3'd5 && !drop) |=> wr_be_o == 8'hFF);
  a_r10_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && drop) |=> !wr_valid_o);
  a_r11_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !wr_valid_o);
endmodule

// File: tb/vga_plane_writer_test.sv
`timescale 1ns/1ps
module vga_plane_writer_test;
  localparam int ADDR_W = 16;
  localparam int OA_W = ADDR_W + 3;

  logic clk = 1'b0, rst_ni = 1'b0, wr_i = 1'b0;
  logic [7:0] cpu_data_i = '0, set_reset_i = '0, sr_enable_i = '0, rot_func_i = '0;
  logic [7:0] mode_reg_i = '0, bit_mask_i = '0, ext_ctrl_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] latch_i = '0;
  logic chain4_i = 1'b0;
  logic [3:0] plane_mask_i = '0;
  logic [OA_W-1:0] limit_i = 19'h20000;
  logic wr_valid_o;
  logic [OA_W-1:0] wr_addr_o;
  logic [63:0] wr_data_o;
  logic [7:0] wr_be_o;

  int checks = 0, fails = 0;
  logic [31:0] lfsr = 32'hACE1_2345;

  always #2 clk = ~clk;

  vga_plane_writer #(.ADDR_W(ADDR_W)) uut (.*, .clk_i(clk));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  logic            e_v;
  logic [7:0]      e_be;
  logic [OA_W-1:0] e_a;
  logic [63:0]     e_d;
  string           tag;

  task automatic model();
    int em;
    logic [OA_W-1:0] base;
    logic [7:0] r, v, m, l, res;
    logic [15:0] t;
    em = ext_ctrl_i[2] ? int'(mode_reg_i[2:0]) : int'(mode_reg_i[1:0]);
    if (chain4_i && em < 4) base = OA_W'(addr_i) & ~OA_W'(3);
    else base = OA_W'(addr_i) * 4;
    e_v = (em < 6) && (base < limit_i);
    e_be = '0; e_d = '0; e_a = '0;
    t = {8'h0, cpu_data_i} << (8 - int'(rot_func_i[2:0]));
    r = (cpu_data_i >> rot_func_i[2:0]) | t[15:8] | t[7:0];
    tag = (em == 0) ? "R5" : (em == 1 || em == 2) ? "R6" : (em == 3) ? "R7" :
          (em == 4) ? "R8" : (em == 5) ? "R9" : "R10";
    if (!e_v) begin
      if (em < 6) tag = "R10";
      return;
    end
    if (em < 4) begin
      e_a = base;
      e_be[3:0] = (chain4_i ? 4'(1 << addr_i[1:0]) : 4'hF) & plane_mask_i;
      for (int p = 0; p < 4; p++) begin
        l = latch_i[p*8 +: 8];
        m = bit_mask_i;
        v = r;
        if (em == 0 && sr_enable_i[p]) v = set_reset_i[p] ? 8'hFF : 8'h00;
        if (em == 2) v = cpu_data_i[p] ? 8'hFF : 8'h00;
        if (em == 3) begin v = set_reset_i[p] ? 8'hFF : 8'h00; m = bit_mask_i & r; end
        case (rot_func_i[4:3])
          2'd0: res = (v & m) | (l & ~m);
          2'd1: res = (v | ~m) & l;
          2'd2: res = (v & m) | l;
          default: res = (v & m) ^ l;
        endcase
        if (em == 1) res = l;
        e_d[p*8 +: 8] = res;
      end
    end else begin
      e_a = base * 2;
      for (int i = 0; i < 8; i++) begin
        e_be[i] = (em == 5) ? 1'b1 : cpu_data_i[7-i];
        e_d[i*8 +: 8] = (em == 5 && !cpu_data_i[7-i]) ? set_reset_i : sr_enable_i;
      end
    end
  endtask

  task automatic check_out(input string t);
    checks++;
    if (wr_valid_o !== e_v || wr_be_o !== e_be ||
        (e_v && (wr_addr_o !== e_a || wr_data_o !== e_d))) begin
      fails++;
      $display("FAIL %s: got v=%0b be=%h a=%h d=%h exp v=%0b be=%h a=%h d=%h",
               t, wr_valid_o, wr_be_o, wr_addr_o, wr_data_o, e_v, e_be, e_a, e_d);
    end
  endtask

  task automatic check_idle(input string t);
    e_v = 1'b0; e_be = '0;
    check_out(t);
  endtask

  task automatic apply();
    model();
    wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
    check_out(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    // sweep: mode field x extension bit x function x chain-4
    for (int i = 0; i < 4096; i++) begin
      lfsr = nxt(lfsr); cpu_data_i = lfsr[7:0]; set_reset_i = lfsr[15:8];
      sr_enable_i = lfsr[23:16]; bit_mask_i = lfsr[31:24];
      lfsr = nxt(lfsr); latch_i = lfsr;
      lfsr = nxt(lfsr); addr_i = lfsr[15:0]; plane_mask_i = lfsr[19:16];
      mode_reg_i = {lfsr[27:23], 3'(i % 8)};
      ext_ctrl_i = {lfsr[31:29], 1'b0, lfsr[28], ((i / 8) % 2) != 0, 2'b00};
      rot_func_i = {3'b000, 2'(i / 16), lfsr[22:20]};
      chain4_i = ((i / 64) % 2) != 0;
      apply();
      if (i % 8 == 7) begin
        @(negedge clk);
        check_idle("R11 idle after write");
      end
    end

    // R2: mode field 5 without extension runs as mode 1
    ext_ctrl_i = 8'h00; mode_reg_i = 8'h05; chain4_i = 1'b0; addr_i = 16'h0010;
    plane_mask_i = 4'hF; latch_i = 32'h1122_3344; apply();
    // R10 boundary: base just under limit, then at limit
    ext_ctrl_i = 8'h04; mode_reg_i = 8'h00; addr_i = 16'h7FFF; apply();
    addr_i = 16'h8000; apply();
    if (e_v) begin fails++; $display("FAIL R10: boundary model accepted, exp drop"); end
    // R8 at top of range
    mode_reg_i = 8'h04; addr_i = 16'h7FFF; cpu_data_i = 8'hA5; apply();
    // R4 replace with full mask passes rotated byte
    mode_reg_i = 8'h00; rot_func_i = 8'h01; bit_mask_i = 8'hFF; sr_enable_i = 8'h00;
    cpu_data_i = 8'h03; addr_i = 16'h0001; apply();
    @(negedge clk);
    check_idle("R11 final idle");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got hung run, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule